// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the two timing signals of a two-channel audio serial link: a bit clock and a left/right frame clock. In master mode it derives both from the master clock input. The bit clock runs at the master clock divided by 2 or 4. The frame clock spans 32, 64 or 128 bit periods per stereo frame. Configurable polarities set which bit-clock edge launches data and which frame-clock level marks the left word. The sample word (16, 24 or 32 bits) is set apart from the frame length. When a half-frame has more slots than the word needs, the bit clock can be held idle through the spare slots.

In slave mode the block drives no clock. It takes the bit and frame clocks from an external device and passes each through a two-flop synchroniser into the master-clock domain. It then turns their edges into single-cycle strobes for the data path. In both modes it reports the current channel and a per-slot enable that tells the serialiser which slots carry sample bits. Out-of-range divider or word settings are clamped to a legal value and reported on an error output.

Top module: `audio_clk_gen`

## Requirements
- R1: Bit-clock divider request `bclk_div_i` maps to B=2 when below 3 and to B=4 otherwise. In master mode, after the k-th rising master-clock edge following reset release, the phase count is k mod B and the bit index is floor(k/B). When `bclk_inv_i`=0, `bclk_o` is low while the phase count is below B/2 and high for the rest of the bit period.
- R2: Frame request `frame_div_i` maps to 32 bit periods when below 48, to 64 when below 96, and to 128 otherwise. Call this F. The channel is left (`chan_o`=0) for the first F/2 bit periods after reset, and it then alternates every F/2 bit periods.
- R3: `config_error_o` is high exactly when `bclk_div_i` is neither 2 nor 4, or `frame_div_i` is none of 32, 64, 128, or `word_len_i` is 3. Word code 3 is treated as 32 bits.
- R4: With `bclk_inv_i`=1 the bit-clock waveform of R1 is inverted, so the data-launch edge at the start of each bit period is rising instead of falling.
- R5: In master mode `lrclk_o` equals `chan_o` XOR `lr_inv_i`. With `lr_inv_i`=0 the frame clock is low during the left word, and with 1 it is low during the right word.
- R6: Word code 0/1/2 selects W=16/24/32 bits. `bit_valid_o` is high when the slot index within the current half-frame is below W. If W is at least F/2, every slot is valid.
- R7: In master mode with `gate_dis_i`=0, `bclk_o` is held at the level `bclk_inv_i` during every slot with index W or above. With `gate_dis_i`=1 the bit clock keeps toggling through those slots.
- R8: In master mode `launch_stb_o` pulses for one master cycle when the phase count is 0, and `capture_stb_o` pulses when it is B/2. The two strobes are never high together.
- R9: In slave mode (`master_i`=0), `clk_oe_o`, `bclk_o` and `lrclk_o` are low. An edge of `bclk_ext_i` shows up as a strobe on the third rising master-clock edge after it. The launch strobe follows the falling external edge when `bclk_inv_i`=0 and the rising edge when it is 1, and the capture strobe follows the other edge.
- R10: In slave mode, each launch strobe takes the channel (synchronised `lrclk_ext_i` XOR `lr_inv_i`). The slot index restarts at 0 when that channel differs from the one at the previous launch strobe, and otherwise counts up, saturating. After reset the previous channel counts as left and no slot is valid until the first channel change.
- R11: While `rst_ni` is low, every output except `config_error_o` and `clk_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| master_i | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| bclk_div_i | input | 3 | Requested master-to-bit clock ratio |
| frame_div_i | input | 8 | Requested bit periods per stereo frame |
| word_len_i | input | 2 | Sample word code: 0=16, 1=24, 2=32 bits |
| bclk_inv_i | input | 1 | Bit-clock polarity (launch edge select) |
| lr_inv_i | input | 1 | Frame-clock polarity |
| gate_dis_i | input | 1 | 1 = keep the bit clock running in unused slots |
| bclk_ext_i | input | 1 | External bit clock (slave mode) |
| lrclk_ext_i | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock |
| lrclk_o | output | 1 | Generated frame clock |
| clk_oe_o | output | 1 | Output enable for both clock pins |
| launch_stb_o | output | 1 | One-cycle strobe at the data-launch edge |
| capture_stb_o | output | 1 | One-cycle strobe at the data-capture edge |
| bit_valid_o | output | 1 | Current slot carries a sample bit |
| chan_o | output | 1 | Current channel, 0 = left, 1 = right |
| config_error_o | output | 1 | A configuration request was clamped |

## Verification
The properties assume the configuration inputs and `master_i` stay fixed while reset is high. Settings change only while `rst_ni` is low, and the stimulus follows this: every configuration vector is applied inside its own reset pulse. In slave mode the external clocks must hold each level for at least three master cycles so that the synchroniser sees every edge. The bench holds each external level for four master cycles and changes the external frame clock only together with the launch edge.

// File: rtl/acg_pkg.sv
package acg_pkg;

  // Legal bit-clock ratios (master cycles per bit period)
  localparam int unsigned BDIV_FAST   = 2;
  localparam int unsigned BDIV_SLOW   = 4;

  // Legal frame lengths (bit periods per stereo frame)
  localparam int unsigned FRAME_SHORT = 32;
  localparam int unsigned FRAME_MID   = 64;
  localparam int unsigned FRAME_LONG  = 128;
  localparam int unsigned FRAME_MAX   = FRAME_LONG;

  // Sample word widths
  localparam int unsigned WORD_NARROW = 16;
  localparam int unsigned WORD_MID    = 24;
  localparam int unsigned WORD_WIDE   = 32;

  typedef enum logic [1:0] {
    WL_16  = 2'd0,
    WL_24  = 2'd1,
    WL_32  = 2'd2,
    WL_RSV = 2'd3
  } word_code_e;

endpackage

// File: rtl/acg_cfg_clamp.sv
module acg_cfg_clamp
  import acg_pkg::*;
#(
  parameter int BDIV_W = 3,
  parameter int FDIV_W = 8,
  parameter int SLOT_W = 6
) (
  input  logic [BDIV_W-1:0] bclk_div_i,
  input  logic [FDIV_W-1:0] frame_div_i,
  input  logic [1:0]        word_len_i,
  output logic [BDIV_W-1:0] bdiv_o,
  output logic [SLOT_W:0]   half_o,
  output logic [SLOT_W:0]   word_o,
  output logic              err_o
);

  localparam logic [BDIV_W-1:0] BD_FAST = BDIV_W'(BDIV_FAST);
  localparam logic [BDIV_W-1:0] BD_SLOW = BDIV_W'(BDIV_SLOW);
  localparam logic [BDIV_W-1:0] BD_MIDP = BDIV_W'((BDIV_FAST + BDIV_SLOW) / 2);

  localparam logic [FDIV_W-1:0] FR_S    = FDIV_W'(FRAME_SHORT);
  localparam logic [FDIV_W-1:0] FR_M    = FDIV_W'(FRAME_MID);
  localparam logic [FDIV_W-1:0] FR_L    = FDIV_W'(FRAME_LONG);
  localparam logic [FDIV_W-1:0] FR_SM   = FDIV_W'((FRAME_SHORT + FRAME_MID) / 2);
  localparam logic [FDIV_W-1:0] FR_ML   = FDIV_W'((FRAME_MID + FRAME_LONG) / 2);

  localparam logic [SLOT_W:0]   HALF_S  = (SLOT_W+1)'(FRAME_SHORT / 2);
  localparam logic [SLOT_W:0]   HALF_M  = (SLOT_W+1)'(FRAME_MID / 2);
  localparam logic [SLOT_W:0]   HALF_L  = (SLOT_W+1)'(FRAME_LONG / 2);

  localparam logic [SLOT_W:0]   WB_N    = (SLOT_W+1)'(WORD_NARROW);
  localparam logic [SLOT_W:0]   WB_M    = (SLOT_W+1)'(WORD_MID);
  localparam logic [SLOT_W:0]   WB_W    = (SLOT_W+1)'(WORD_WIDE);

  logic bdiv_bad, fdiv_bad, word_bad;

  // Bit-clock ratio: round to nearest legal value, ties go to the slower one
  always_comb begin
    bdiv_o   = (bclk_div_i < BD_MIDP) ? BD_FAST : BD_SLOW;
    bdiv_bad = (bclk_div_i != BD_FAST) && (bclk_div_i != BD_SLOW);
  end

  // Frame length: round to nearest legal value, ties go to the longer one
  always_comb begin
    if (frame_div_i < FR_SM) begin
      half_o = HALF_S;
    end else if (frame_div_i < FR_ML) begin
      half_o = HALF_M;
    end else begin
      half_o = HALF_L;
    end
    fdiv_bad = (frame_div_i != FR_S) && (frame_div_i != FR_M) &&
               (frame_div_i != FR_L);
  end

  // Word width decode; the reserved code falls back to the widest word
  always_comb begin
    word_bad = 1'b0;
    case (word_code_e'(word_len_i))
      WL_16:   word_o = WB_N;
      WL_24:   word_o = WB_M;
      WL_32:   word_o = WB_W;
      default: begin
        word_o   = WB_W;
        word_bad = 1'b1;
      end
    endcase
  end

  assign err_o = bdiv_bad | fdiv_bad | word_bad;

endmodule

// File: rtl/acg_master_gen.sv
module acg_master_gen #(
  parameter int BDIV_W = 3,
  parameter int SLOT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [BDIV_W-1:0] bdiv_i,
  input  logic [SLOT_W:0]   half_i,
  input  logic [SLOT_W:0]   word_i,
  input  logic              bclk_inv_i,
  input  logic              lr_inv_i,
  input  logic              gate_dis_i,
  output logic              bclk_o,
  output logic              lrclk_o,
  output logic              launch_o,
  output logic              capture_o,
  output logic              valid_o,
  output logic              chan_o
);

  logic [BDIV_W-1:0] div_q, div_n;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic              chan_q, chan_n;

  logic [BDIV_W-1:0] div_last, div_mid;
  logic [SLOT_W:0]   half_last;
  logic              bit_wrap, half_wrap;

  logic              valid_n, gate_n;
  logic              bclk_n, lrclk_n, launch_n, capture_n;

  assign div_last  = bdiv_i - 1'b1;
  assign div_mid   = bdiv_i >> 1;
  assign half_last = half_i - 1'b1;
  assign bit_wrap  = (div_q == div_last);
  assign half_wrap = ({1'b0, slot_q} == half_last);

  // Counter next state
  always_comb begin
    div_n  = div_q;
    slot_n = slot_q;
    chan_n = chan_q;
    if (en_i) begin
      if (bit_wrap) begin
        div_n = '0;
        if (half_wrap) begin
          slot_n = '0;
          chan_n = ~chan_q;
        end else begin
          slot_n = slot_q + 1'b1;
        end
      end else begin
        div_n = div_q + 1'b1;
      end
    end else begin
      div_n  = '0;
      slot_n = '0;
      chan_n = 1'b0;
    end
  end

  // Output decode from the next state so the pins line up with the counters
  always_comb begin
    valid_n   = ({1'b0, slot_n} < word_i);
    gate_n    = ~valid_n & ~gate_dis_i;
    bclk_n    = en_i & (gate_n ? bclk_inv_i : ((div_n >= div_mid) ^ bclk_inv_i));
    lrclk_n   = en_i & (chan_n ^ lr_inv_i);
    launch_n  = en_i & (div_n == '0);
    capture_n = en_i & (div_n == div_mid);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      slot_q    <= '0;
      chan_q    <= 1'b0;
      bclk_o    <= 1'b0;
      lrclk_o   <= 1'b0;
      launch_o  <= 1'b0;
      capture_o <= 1'b0;
      valid_o   <= 1'b0;
      chan_o    <= 1'b0;
    end else begin
      div_q     <= div_n;
      slot_q    <= slot_n;
      chan_q    <= chan_n;
      bclk_o    <= bclk_n;
      lrclk_o   <= lrclk_n;
      launch_o  <= launch_n;
      capture_o <= capture_n;
      valid_o   <= en_i & valid_n;
      chan_o    <= en_i & chan_n;
    end
  end

endmodule

// File: rtl/acg_slave_sync.sv
module acg_slave_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_W      = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            bclk_ext_i,
  input  logic            lrclk_ext_i,
  input  logic            bclk_inv_i,
  input  logic            lr_inv_i,
  input  logic [SLOT_W:0] word_i,
  output logic            launch_o,
  output logic            capture_o,
  output logic            valid_o,
  output logic            chan_o
);

  localparam logic [SLOT_W-1:0] SLOT_IDLE = '1;

  // Synchroniser chain: bit 1 = frame clock, bit 0 = bit clock
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    logic [1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 2'b00;
        else         q <= {lrclk_ext_i, bclk_ext_i};
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 2'b00;
        else         q <= g_stage[g-1].q;
      end
    end
  end

  logic [1:0]        sync_s;
  logic              hist_q;
  logic              rise, fall, launch_det, capture_det, chan_now;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic              chan_q, chan_n;

  assign sync_s      = g_stage[SYNC_STAGES-1].q;
  assign rise        = sync_s[0] & ~hist_q;
  assign fall        = ~sync_s[0] & hist_q;
  assign launch_det  = en_i & (bclk_inv_i ? rise : fall);
  assign capture_det = en_i & (bclk_inv_i ? fall : rise);
  assign chan_now    = sync_s[1] ^ lr_inv_i;

  // Slot tracking, advanced only on the launch edge
  always_comb begin
    slot_n = slot_q;
    chan_n = chan_q;
    if (!en_i) begin
      slot_n = SLOT_IDLE;
      chan_n = 1'b0;
    end else if (launch_det) begin
      chan_n = chan_now;
      if (chan_now != chan_q) begin
        slot_n = '0;
      end else if (slot_q != SLOT_IDLE) begin
        slot_n = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q    <= 1'b0;
      slot_q    <= SLOT_IDLE;
      chan_q    <= 1'b0;
      launch_o  <= 1'b0;
      capture_o <= 1'b0;
    end else begin
      hist_q    <= sync_s[0];
      slot_q    <= slot_n;
      chan_q    <= chan_n;
      launch_o  <= launch_det;
      capture_o <= capture_det;
    end
  end

  assign valid_o = en_i & (slot_q != SLOT_IDLE) & ({1'b0, slot_q} < word_i);
  assign chan_o  = chan_q;

endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
  import acg_pkg::*;
#(
  parameter int BDIV_W      = 3,
  parameter int FDIV_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic [BDIV_W-1:0] bclk_div_i,
  input  logic [FDIV_W-1:0] frame_div_i,
  input  logic [1:0]        word_len_i,
  input  logic              bclk_inv_i,
  input  logic              lr_inv_i,
  input  logic              gate_dis_i,
  input  logic              bclk_ext_i,
  input  logic              lrclk_ext_i,
  output logic              bclk_o,
  output logic              lrclk_o,
  output logic              clk_oe_o,
  output logic              launch_stb_o,
  output logic              capture_stb_o,
  output logic              bit_valid_o,
  output logic              chan_o,
  output logic              config_error_o
);

  localparam int SLOT_W = $clog2(FRAME_MAX / 2);

  logic [BDIV_W-1:0] bdiv;
  logic [SLOT_W:0]   half_len, word_bits;

  logic m_bclk, m_lrclk, m_launch, m_capture, m_valid, m_chan;
  logic s_launch, s_capture, s_valid, s_chan;

  acg_cfg_clamp #(
    .BDIV_W (BDIV_W),
    .FDIV_W (FDIV_W),
    .SLOT_W (SLOT_W)
  ) u_cfg (
    .bclk_div_i  (bclk_div_i),
    .frame_div_i (frame_div_i),
    .word_len_i  (word_len_i),
    .bdiv_o      (bdiv),
    .half_o      (half_len),
    .word_o      (word_bits),
    .err_o       (config_error_o)
  );

  acg_master_gen #(
    .BDIV_W (BDIV_W),
    .SLOT_W (SLOT_W)
  ) u_master (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (master_i),
    .bdiv_i     (bdiv),
    .half_i     (half_len),
    .word_i     (word_bits),
    .bclk_inv_i (bclk_inv_i),
    .lr_inv_i   (lr_inv_i),
    .gate_dis_i (gate_dis_i),
    .bclk_o     (m_bclk),
    .lrclk_o    (m_lrclk),
    .launch_o   (m_launch),
    .capture_o  (m_capture),
    .valid_o    (m_valid),
    .chan_o     (m_chan)
  );

  acg_slave_sync #(
    .SYNC_STAGES (SYNC_STAGES),
    .SLOT_W      (SLOT_W)
  ) u_slave (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (~master_i),
    .bclk_ext_i  (bclk_ext_i),
    .lrclk_ext_i (lrclk_ext_i),
    .bclk_inv_i  (bclk_inv_i),
    .lr_inv_i    (lr_inv_i),
    .word_i      (word_bits),
    .launch_o    (s_launch),
    .capture_o   (s_capture),
    .valid_o     (s_valid),
    .chan_o      (s_chan)
  );

  // The master generator parks its outputs low when disabled
  assign clk_oe_o      = master_i;
  assign bclk_o        = m_bclk;
  assign lrclk_o       = m_lrclk;
  assign launch_stb_o  = master_i ? m_launch  : s_launch;
  assign capture_stb_o = master_i ? m_capture : s_capture;
  assign bit_valid_o   = master_i ? m_valid   : s_valid;
  assign chan_o        = master_i ? m_chan    : s_chan;

endmodule

// File: rtl/acg_checker.sv
module acg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic master_i,
  input logic bclk_inv_i,
  input logic gate_dis_i,
  input logic bclk_o,
  input logic lrclk_o,
  input logic clk_oe_o,
  input logic launch_stb_o,
  input logic capture_stb_o,
  input logic bit_valid_o
);

  // Becomes 2'b11 once two edges have passed since reset release
  logic [1:0] armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 2'b00;
    else         armed_q <= {armed_q[0], 1'b1};
  end

  AST_STB_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch_stb_o && capture_stb_o)); // R8

  AST_LAUNCH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_stb_o |=> !launch_stb_o); // R8

  AST_SLAVE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q[0] && !master_i && !$past(master_i)) |-> (!clk_oe_o && !bclk_o && !lrclk_o)); // R9

  AST_GATE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q[0] && master_i && !gate_dis_i && !bit_valid_o) |-> (bclk_o == bclk_inv_i)); // R7

  AST_LR_ON_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q[1] && master_i && $past(master_i) && !$stable(lrclk_o)) |-> launch_stb_o); // R2

endmodule

bind audio_clk_gen acg_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .master_i      (master_i),
  .bclk_inv_i    (bclk_inv_i),
  .gate_dis_i    (gate_dis_i),
  .bclk_o        (bclk_o),
  .lrclk_o       (lrclk_o),
  .clk_oe_o      (clk_oe_o),
  .launch_stb_o  (launch_stb_o),
  .capture_stb_o (capture_stb_o),
  .bit_valid_o   (bit_valid_o)
);

// File: tb/audio_clk_gen_tb.sv
module audio_clk_gen_tb;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       master_i;
  logic [2:0] bclk_div_i;
  logic [7:0] frame_div_i;
  logic [1:0] word_len_i;
  logic       bclk_inv_i, lr_inv_i, gate_dis_i;
  logic       bclk_ext_i, lrclk_ext_i;
  logic       bclk_o, lrclk_o, clk_oe_o, launch_stb_o, capture_stb_o;
  logic       bit_valid_o, chan_o, config_error_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  audio_clk_gen u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .master_i       (master_i),
    .bclk_div_i     (bclk_div_i),
    .frame_div_i    (frame_div_i),
    .word_len_i     (word_len_i),
    .bclk_inv_i     (bclk_inv_i),
    .lr_inv_i       (lr_inv_i),
    .gate_dis_i     (gate_dis_i),
    .bclk_ext_i     (bclk_ext_i),
    .lrclk_ext_i    (lrclk_ext_i),
    .bclk_o         (bclk_o),
    .lrclk_o        (lrclk_o),
    .clk_oe_o       (clk_oe_o),
    .launch_stb_o   (launch_stb_o),
    .capture_stb_o  (capture_stb_o),
    .bit_valid_o    (bit_valid_o),
    .chan_o         (chan_o),
    .config_error_o (config_error_o)
  );

  // Vector: [15:13] bit divider, [12:5] frame request, [4:3] word code,
  //         [2] bit-clock polarity, [1] frame polarity, [0] gating disable
  localparam int NVEC = 8;
  localparam logic [15:0] VEC [NVEC] = '{
    {3'd2, 8'd64,  2'd0, 1'b0, 1'b0, 1'b0},
    {3'd4, 8'd32,  2'd0, 1'b1, 1'b0, 1'b0},
    {3'd4, 8'd128, 2'd1, 1'b0, 1'b1, 1'b0},
    {3'd2, 8'd128, 2'd2, 1'b1, 1'b1, 1'b1},
    {3'd3, 8'd96,  2'd3, 1'b0, 1'b0, 1'b0},
    {3'd1, 8'd40,  2'd0, 1'b0, 1'b0, 1'b0},
    {3'd7, 8'd70,  2'd1, 1'b1, 1'b0, 1'b0},
    {3'd2, 8'd32,  2'd2, 1'b0, 1'b1, 1'b0}
  };

  function automatic int exp_bdiv(input int raw);
    return (raw < 3) ? 2 : 4;
  endfunction

  function automatic int exp_frame(input int raw);
    if (raw < 48) return 32;
    if (raw < 96) return 64;
    return 128;
  endfunction

  function automatic int exp_word(input int code);
    if (code == 0) return 16;
    if (code == 1) return 24;
    return 32;
  endfunction

  function automatic bit exp_err(input int b, input int f, input int w);
    return !(b == 2 || b == 4) || !(f == 32 || f == 64 || f == 128) || (w == 3);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Drive one external bit period; the first edge is the launch edge
  task automatic ext_bit(input logic lr, input logic inv, input int slot, input logic ch);
    lrclk_ext_i = lr;
    bclk_ext_i  = inv;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (i == 1) begin
        check("R9 clk_oe", clk_oe_o, 0);
        check("R9 bclk_o", bclk_o, 0);
      end
      if (i == 3) check("R9 launch", launch_stb_o, 1);
    end
    bclk_ext_i = ~inv;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (i == 2) begin
        check("R10 valid", bit_valid_o, (slot >= 0 && slot < 16) ? 1 : 0);
        if (slot >= 0) check("R10 chan", chan_o, ch);
      end
      if (i == 3) check("R9 capture", capture_stb_o, 1);
    end
  endtask

  initial begin
    rst_ni      = 1'b0;
    master_i    = 1'b1;
    bclk_div_i  = 3'd2;
    frame_div_i = 8'd32;
    word_len_i  = 2'd0;
    bclk_inv_i  = 1'b0;
    lr_inv_i    = 1'b0;
    gate_dis_i  = 1'b0;
    bclk_ext_i  = 1'b0;
    lrclk_ext_i = 1'b0;

    // Table-driven master-mode runs
    for (int v = 0; v < NVEC; v++) begin
      int rb, rf, rw, B, F, W, half, cycles;
      bit inv, lri, gd;
      rb  = int'(VEC[v][15:13]);
      rf  = int'(VEC[v][12:5]);
      rw  = int'(VEC[v][4:3]);
      inv = VEC[v][2];
      lri = VEC[v][1];
      gd  = VEC[v][0];
      master_i    = 1'b1;
      bclk_div_i  = VEC[v][15:13];
      frame_div_i = VEC[v][12:5];
      word_len_i  = VEC[v][4:3];
      bclk_inv_i  = inv;
      lr_inv_i    = lri;
      gate_dis_i  = gd;
      apply_reset();
      B = exp_bdiv(rb);
      F = exp_frame(rf);
      W = exp_word(rw);
      half = F / 2;
      // R11: reset state
      check("R11 bclk", bclk_o, 0);
      check("R11 lrclk", lrclk_o, 0);
      check("R11 launch", launch_stb_o, 0);
      check("R11 valid", bit_valid_o, 0);
      check("R3 config_error", config_error_o, exp_err(rb, rf, rw));
      rst_ni = 1'b1;
      cycles = B * F * 2 + 3;
      for (int k = 1; k <= cycles; k++) begin
        int d, b, slot, ch, val, gate, ebclk;
        @(negedge clk);
        d     = k % B;
        b     = k / B;
        slot  = b % half;
        ch    = (b / half) % 2;
        val   = (slot < W) ? 1 : 0;
        gate  = (!val && !gd) ? 1 : 0;
        ebclk = gate ? inv : (((d >= B / 2) ? 1 : 0) ^ inv);
        if (gate)     check("R7 gated bclk", bclk_o, ebclk);
        else if (inv) check("R4 bclk", bclk_o, ebclk);
        else          check("R1 bclk", bclk_o, ebclk);
        check("R2 chan", chan_o, ch);
        check("R5 lrclk", lrclk_o, ch ^ lri);
        check("R6 valid", bit_valid_o, val);
        check("R8 launch", launch_stb_o, (d == 0) ? 1 : 0);
        check("R8 capture", capture_stb_o, (d == B / 2) ? 1 : 0);
        check("R9 clk_oe master", clk_oe_o, 1);
      end
    end

    // Directed: slave mode, both launch-edge polarities
    for (int p = 0; p < 2; p++) begin
      logic inv;
      int pre;
      inv         = p[0];
      master_i    = 1'b0;
      word_len_i  = 2'd0;
      bclk_div_i  = 3'd2;
      frame_div_i = 8'd32;
      bclk_inv_i  = inv;
      lr_inv_i    = 1'b0;
      bclk_ext_i  = ~inv;
      lrclk_ext_i = 1'b0;
      apply_reset();
      check("R11 slave chan", chan_o, 0);
      check("R11 slave valid", bit_valid_o, 0);
      rst_ni = 1'b1;
      repeat (10) @(negedge clk);
      pre = (p == 0) ? 4 : 2;
      // Left before any frame-clock change: no valid slot yet (R10)
      for (int i = 0; i < pre; i++) ext_bit(1'b0, inv, -1, 1'b0);
      for (int i = 0; i < 20; i++)  ext_bit(1'b1, inv, i, 1'b1);
      for (int i = 0; i < 20; i++)  ext_bit(1'b0, inv, i, 1'b0);
    end

    // Directed: R3 boundary values during reset
    master_i    = 1'b1;
    bclk_div_i  = 3'd4;
    frame_div_i = 8'd128;
    word_len_i  = 2'd2;
    apply_reset();
    check("R3 legal extremes", config_error_o, 0);
    frame_div_i = 8'd0;
    @(negedge clk);
    check("R3 zero frame", config_error_o, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule